// File: doc/BRIEF.md
# Host bus reset sequencer

This block brings an external parallel bus out of reset before a host bridge uses it. After a `start` pulse, it sets four bus control bits in a fixed order. First it turns on the reset and clock output drivers while the bus is still held in reset. Next it starts the bus clock. It keeps reset asserted for a minimum hold time, then releases it. After that it switches the bus arbiter to internal mode and waits a short guard time.

When a card-slot bridge is present, the block then drives a bridge-reset general-purpose output high, with its output enable on. A long settling period follows, and then `ready` goes high. `ready` stays high until the next synchronous reset.

All delays come from a clock frequency parameter and from microsecond parameters, and each delay is rounded up to whole cycles. Every control bit is registered, and once set it stays set until reset. `start` has no effect while a sequence is running or after it has completed.

Top module: `bus_rst_seq`

## Requirements
- R1: A synchronous active-high `rst` clears every output to 0 at the next clock edge, including in the middle of a sequence.
- R2: In idle, `start` sampled high at an edge sets `bus_rst_drv_en` and `bus_clk_drv_en` at that edge, while `bus_clk_run` and `bus_rst_release` stay 0.
- R3: `bus_clk_run` rises exactly one cycle after the drivers are enabled, and both driver enables remain set.
- R4: `bus_rst_release` rises exactly HOLD+1 cycles after `bus_clk_run` and never earlier than HOLD cycles after it. HOLD = ceil(CLK_FREQ_HZ*CLK_HOLD_US/1e6), with a minimum of 1.
- R5: `arb_internal` rises one cycle after `bus_rst_release`.
- R6: ARB+1 cycles after `arb_internal` rises, where ARB = ceil(CLK_FREQ_HZ*ARB_HOLD_US/1e6): if `cardbus_present` is 1, both `bridge_gpio_out` and `bridge_gpio_oe` go to 1; if it is 0, both stay 0.
- R7: `ready` rises SETTLE+1 cycles after the bridge-reset step, where SETTLE = ceil(CLK_FREQ_HZ*SETTLE_US/1e6), and then stays 1.
- R8: `start` is ignored while a sequence is in progress and after `ready` is high: the output timing and values do not change.
- R9: Once any output bit has been set, it stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the sequence when idle |
| cardbus_present | input | 1 | A card-slot bridge needs its reset output driven |
| bus_rst_drv_en | output | 1 | Output enable for the bus reset driver |
| bus_clk_drv_en | output | 1 | Output enable for the bus clock driver |
| bus_clk_run | output | 1 | Bus clock running |
| bus_rst_release | output | 1 | Bus reset deasserted |
| arb_internal | output | 1 | Bus arbiter set to internal mode |
| bridge_gpio_out | output | 1 | Bridge-reset GPIO level |
| bridge_gpio_oe | output | 1 | Bridge-reset GPIO output enable |
| ready | output | 1 | Sequence complete |

## Verification
A wrong state or an off-by-one in a counter shows at the ports as a control bit that changes one cycle early or late. The bench therefore compares the full output vector in the cycle before each expected change and in the cycle of the change. A state machine that mistakes a repeated `start` for a new sequence shifts every later edge, so the error appears hundreds of cycles later, at the release or ready edge. A lost sticky bit appears on the very next cycle as an output falling back to 0.

// File: rtl/bus_rst_seq_pkg.sv
package bus_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRV,
    ST_HOLD,
    ST_ARB,
    ST_ARB_WAIT,
    ST_SETTLE,
    ST_DONE
  } seq_state_e;

  // Round a microsecond delay up to whole clock cycles, never below one.
  function automatic longint unsigned us_to_cycles(input longint unsigned freq_hz,
                                                   input longint unsigned usec);
    longint unsigned cyc;
    cyc = (freq_hz * usec + 64'd999_999) / 64'd1_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return cyc;
  endfunction

  function automatic longint unsigned max3(input longint unsigned a,
                                           input longint unsigned b,
                                           input longint unsigned c);
    longint unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bus_rst_seq_timer.sv
module bus_rst_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bus_rst_seq_fsm.sv
module bus_rst_seq_fsm
  import bus_rst_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] HOLD_VAL = 1,
  parameter logic [CNT_W-1:0] ARB_VAL = 1,
  parameter logic [CNT_W-1:0] SETTLE_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cardbus_present,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             rst_drv_en,
  output logic             clk_drv_en,
  output logic             clk_run,
  output logic             rst_release,
  output logic             arb_int,
  output logic             gpio_out,
  output logic             gpio_oe,
  output logic             rdy
);
  seq_state_e state, state_nxt;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      ST_IDLE:     if (start) state_nxt = ST_DRV;
      ST_DRV: begin
        state_nxt = ST_HOLD;
        tmr_load  = 1'b1;
        tmr_val   = HOLD_VAL;
      end
      ST_HOLD:     if (tmr_expired) state_nxt = ST_ARB;
      ST_ARB: begin
        state_nxt = ST_ARB_WAIT;
        tmr_load  = 1'b1;
        tmr_val   = ARB_VAL;
      end
      ST_ARB_WAIT: if (tmr_expired) begin
        state_nxt = ST_SETTLE;
        tmr_load  = 1'b1;
        tmr_val   = SETTLE_VAL;
      end
      ST_SETTLE:   if (tmr_expired) state_nxt = ST_DONE;
      ST_DONE:     state_nxt = ST_DONE;
      default:     state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rst_drv_en  <= 1'b0;
      clk_drv_en  <= 1'b0;
      clk_run     <= 1'b0;
      rst_release <= 1'b0;
      arb_int     <= 1'b0;
      gpio_out    <= 1'b0;
      gpio_oe     <= 1'b0;
      rdy         <= 1'b0;
    end else begin
      state <= state_nxt;
      if (state == ST_IDLE && start) begin
        rst_drv_en <= 1'b1;
        clk_drv_en <= 1'b1;
      end
      if (state == ST_DRV) clk_run <= 1'b1;
      if (state == ST_HOLD && tmr_expired) rst_release <= 1'b1;
      if (state == ST_ARB) arb_int <= 1'b1;
      if (state == ST_ARB_WAIT && tmr_expired && cardbus_present) begin
        gpio_out <= 1'b1;
        gpio_oe  <= 1'b1;
      end
      if (state == ST_SETTLE && tmr_expired) rdy <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_rst_seq.sv
module bus_rst_seq
  import bus_rst_seq_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
  parameter longint unsigned CLK_HOLD_US = 150,
  parameter longint unsigned ARB_HOLD_US = 1,
  parameter longint unsigned SETTLE_US   = 10_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cardbus_present,
  output logic bus_rst_drv_en,
  output logic bus_clk_drv_en,
  output logic bus_clk_run,
  output logic bus_rst_release,
  output logic arb_internal,
  output logic bridge_gpio_out,
  output logic bridge_gpio_oe,
  output logic ready
);
  localparam longint unsigned HOLD_CYC   = us_to_cycles(CLK_FREQ_HZ, CLK_HOLD_US);
  localparam longint unsigned ARB_CYC    = us_to_cycles(CLK_FREQ_HZ, ARB_HOLD_US);
  localparam longint unsigned SETTLE_CYC = us_to_cycles(CLK_FREQ_HZ, SETTLE_US);
  localparam longint unsigned MAX_CYC    = max3(HOLD_CYC, ARB_CYC, SETTLE_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  bus_rst_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  bus_rst_seq_fsm #(
    .CNT_W      (CNT_W),
    .HOLD_VAL   (CNT_W'(HOLD_CYC)),
    .ARB_VAL    (CNT_W'(ARB_CYC)),
    .SETTLE_VAL (CNT_W'(SETTLE_CYC))
  ) u_fsm (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .cardbus_present (cardbus_present),
    .tmr_expired     (tmr_expired),
    .tmr_load        (tmr_load),
    .tmr_val         (tmr_val),
    .rst_drv_en      (bus_rst_drv_en),
    .clk_drv_en      (bus_clk_drv_en),
    .clk_run         (bus_clk_run),
    .rst_release     (bus_rst_release),
    .arb_int         (arb_internal),
    .gpio_out        (bridge_gpio_out),
    .gpio_oe         (bridge_gpio_oe),
    .rdy             (ready)
  );
endmodule

// File: rtl/bus_rst_seq_chk.sv
module bus_rst_seq_chk
  import bus_rst_seq_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
  parameter longint unsigned CLK_HOLD_US = 150,
  parameter longint unsigned ARB_HOLD_US = 1,
  parameter longint unsigned SETTLE_US   = 10_000
) (
  input logic clk,
  input logic rst,
  input logic bus_rst_drv_en,
  input logic bus_clk_drv_en,
  input logic bus_clk_run,
  input logic bus_rst_release,
  input logic arb_internal,
  input logic bridge_gpio_out,
  input logic bridge_gpio_oe,
  input logic ready
);
  localparam int unsigned HOLD_C = 32'(us_to_cycles(CLK_FREQ_HZ, CLK_HOLD_US));
  localparam int unsigned ARB_C  = 32'(us_to_cycles(CLK_FREQ_HZ, ARB_HOLD_US));
  localparam int unsigned SET_C  = 32'(us_to_cycles(CLK_FREQ_HZ, SETTLE_US));

  logic [7:0]  outs;
  logic        rst_q = 1'b0;
  int unsigned clk_on_cnt;
  int unsigned arb_cnt;

  assign outs = {ready, bridge_gpio_oe, bridge_gpio_out, arb_internal,
                 bus_rst_release, bus_clk_run, bus_clk_drv_en, bus_rst_drv_en};

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      clk_on_cnt <= 0;
      arb_cnt    <= 0;
    end else begin
      if (bus_clk_run) clk_on_cnt <= clk_on_cnt + 1;
      if (arb_internal) arb_cnt <= arb_cnt + 1;
    end
  end

  // R1: outputs cleared the cycle after reset is sampled
  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_clear_r1: assert (outs == 8'h00)
        else $error("reset did not clear outputs");
    end
  end

  p_drivers_with_clk_r3: assert property (@(posedge clk) disable iff (rst)
    bus_clk_run |-> (bus_rst_drv_en && bus_clk_drv_en));

  p_release_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rst_release) |-> (bus_clk_run && clk_on_cnt >= HOLD_C));

  p_arb_after_release_r5: assert property (@(posedge clk) disable iff (rst)
    arb_internal |-> bus_rst_release);

  p_gpio_after_arb_r6: assert property (@(posedge clk) disable iff (rst)
    bridge_gpio_oe |-> (arb_internal && bridge_gpio_out));

  p_ready_settle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (arb_cnt >= ARB_C + SET_C));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (outs != 8'h00) |=> ((outs & $past(outs)) == $past(outs)));
endmodule

bind bus_rst_seq bus_rst_seq_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ),
  .CLK_HOLD_US (CLK_HOLD_US),
  .ARB_HOLD_US (ARB_HOLD_US),
  .SETTLE_US   (SETTLE_US)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_rst_drv_en  (bus_rst_drv_en),
  .bus_clk_drv_en  (bus_clk_drv_en),
  .bus_clk_run     (bus_clk_run),
  .bus_rst_release (bus_rst_release),
  .arb_internal    (arb_internal),
  .bridge_gpio_out (bridge_gpio_out),
  .bridge_gpio_oe  (bridge_gpio_oe),
  .ready           (ready)
);

// File: tb/test_bus_rst_seq.sv
module test_bus_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned F_HZ = 2_000_000;
  // Expected delays in cycles, rounded up: 150 us, 1 us, 10 ms at 2 MHz
  localparam int H = 300;
  localparam int A = 2;
  localparam int S = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cardbus_present = 1'b0;
  logic bus_rst_drv_en, bus_clk_drv_en, bus_clk_run, bus_rst_release;
  logic arb_internal, bridge_gpio_out, bridge_gpio_oe, ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_rst_seq #(.CLK_FREQ_HZ(F_HZ)) i_bus_rst_seq (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .cardbus_present (cardbus_present),
    .bus_rst_drv_en  (bus_rst_drv_en),
    .bus_clk_drv_en  (bus_clk_drv_en),
    .bus_clk_run     (bus_clk_run),
    .bus_rst_release (bus_rst_release),
    .arb_internal    (arb_internal),
    .bridge_gpio_out (bridge_gpio_out),
    .bridge_gpio_oe  (bridge_gpio_oe),
    .ready           (ready)
  );

  typedef struct {
    int         cyc;
    logic [7:0] vec;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   edge_cnt = 0;
  int   n_cmp = 0;
  int   n_bad = 0;

  // Output vector: {ready, gpio_oe, gpio_out, arb, release, clk_run, clk_drv, rst_drv}
  wire [7:0] outs = {ready, bridge_gpio_oe, bridge_gpio_out, arb_internal,
                     bus_rst_release, bus_clk_run, bus_clk_drv_en, bus_rst_drv_en};

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // Monitor: compare queued expectations at the negedge of their cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc == edge_cnt) begin
      n_cmp++;
      if (outs !== exp_q[0].vec) begin
        n_bad++;
        $display("FAIL %s at edge %0d: got %b expected %b",
                 exp_q[0].req, edge_cnt, outs, exp_q[0].vec);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic push(input int cyc, input logic [7:0] vec, input string req);
    exp_t e;
    e.cyc = cyc; e.vec = vec; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  // Driver: start a sequence, push every expected edge, optionally re-pulse start
  task automatic run_seq(input logic cb, input bit extra_start);
    int b;
    logic [7:0] v5;
    v5 = cb ? 8'b0111_1111 : 8'b0001_1111;
    cardbus_present = cb;
    @(negedge clk); #1;
    b = edge_cnt;
    push(b+1,         8'b0000_0011, "R2");
    push(b+2,         8'b0000_0111, "R3");
    push(b+2+H,       8'b0000_0111, "R4");
    push(b+3+H,       8'b0000_1111, "R4");
    push(b+4+H,       8'b0001_1111, "R5");
    push(b+4+H+A,     8'b0001_1111, "R6");
    push(b+5+H+A,     v5,           "R6");
    push(b+5+H+A+S,   v5,           "R7");
    push(b+6+H+A+S,   v5 | 8'h80,   "R7");
    push(b+6+H+A+S+40, v5 | 8'h80,  "R7");
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (extra_start) begin
      // R8: re-pulse start during the hold and the settle phases
      repeat (50) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
      repeat (H + 100) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
    end
    wait_drain();
    if (extra_start) begin
      // R8: start after completion leaves everything unchanged
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
      push(edge_cnt + 3,   v5 | 8'h80, "R8");
      push(edge_cnt + H+4, v5 | 8'h80, "R8");
      wait_drain();
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst = 1'b1;
    push(edge_cnt + 1, 8'h00, "R1");
    push(edge_cnt + 2, 8'h00, "R1");
    @(negedge clk); @(negedge clk); #1 rst = 1'b0;
    wait_drain();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, queue depth %0d expected 0", exp_q.size());
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    n_cmp++;
    if (outs !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 reset state: got %b expected %b", outs, 8'h00);
    end
    #1 rst = 1'b0;
    // R1 idle holds: no start, nothing moves
    push(edge_cnt + 20, 8'h00, "R1");
    wait_drain();

    // Sequence without a card slot, with ignored start pulses (R6 gpio low, R8)
    run_seq(1'b0, 1'b1);

    // R1: reset in the middle of a sequence
    do_reset();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    repeat (10) @(negedge clk);
    do_reset();

    // Sequence with a card slot present (R6 gpio high), R9 sticky checked by edges
    run_seq(1'b1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule